// File: doc/BRIEF.md
# I2C-Controlled 8-Bit GPIO Expander

This block is a target on a two-wire serial bus. Through a small register file it controls one 8-bit general-purpose port. A host starts a transfer and sends a 7-bit target address and a direction bit. In a write, the next byte is a command that points at one of four registers, and any number of data bytes follow. All of those data bytes land in the register that the command selected. A read returns the selected register again and again until the host declines a byte.

The bus lines are open-drain. Each appears as a sampled input plus an output that, when high, pulls the line low. Both inputs pass through a synchroniser clocked by the system clock, and every bus event is found by comparing successive synchronised samples. Two strap inputs complete the address. The port has an input vector, an output vector and a per-bit drive enable. The bus carries no back-pressure beyond acknowledge. There is no clock stretching, so the clock pull-down output stays inactive.

Top module: `i2c_port_expander`

## Requirements
- R1: The target answers only the address whose upper five bits are 1,1,1,0,0 and whose two low bits equal strap_i[1] then strap_i[0], sent MSB first. A mismatch gets no acknowledge, and every byte up to the next START is ignored.
- R2: The target acknowledges by pulling SDA low for the whole ninth clock. It does so after a matching address, after an accepted command and after every data byte of a write.
- R3: Command values select registers: 0x00 input, 0x01 output, 0x02 polarity, 0x03 direction. Any other command is not acknowledged, and no register changes before the next START.
- R4: A data byte written to the output register appears on pin_out_o on the SCL falling edge that ends its acknowledge clock, not earlier. Every data byte of one write goes to the same register.
- R5: A direction bit of 1 makes that pin an input (pin_drive_o bit 0). A direction bit of 0 makes it a driven output (pin_drive_o bit 1).
- R6: A read sends the register chosen by the last accepted command, MSB first. Each byte repeats that register until the host does not acknowledge, after which SDA is released. The input register reads as pin_in_i XOR polarity.
- R7: After reset the output register is 0xFF, polarity is 0x00, direction is 0xFF (no pin driven), the pointer is 0x00 and SDA is released.
- R8: START is SDA falling while SCL is high, and it restarts address reception even in the middle of a byte. STOP is SDA rising while SCL is high, and it returns the target to idle.
- R9: The target begins pulling SDA low only while SCL is low.
- R10: Data bytes written with command 0x00 are acknowledged and change no register.
- R11: The SCL pull-down output is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| scl_low_o | output | 1 | SCL pull-down enable (always 0) |
| sda_i | input | 1 | Sampled SDA line |
| sda_low_o | output | 1 | SDA pull-down enable |
| strap_i | input | 2 | Address strap bits {A1, A0} |
| pin_in_i | input | 8 | Port input levels |
| pin_out_o | output | 8 | Port output register value |
| pin_drive_o | output | 8 | Per-bit output drive enable |

## Verification
The bench focuses on four risks.

- **Output update timing.** The port output is compared on every clock against a model that moves only at the fall ending each acknowledge clock. A design that commits at the eighth bit, or one cycle late, shows a miscompare.
- **Rejected transfers.** An address with the wrong strap bits and an unknown command are both sent, followed by data bytes. A design that acknowledges them or lets the data through changes the pins.
- **Repeated reads.** Reads are chained after a repeated START. A design that advances the pointer, or that drops the polarity XOR, returns wrong bytes.
- **Broken bytes.** A START is sent in the middle of a byte. A design that keeps the partial bits misses the next address.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_PREFIX = 5'b11100;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WDATA, PH_RDATA, PH_RACK
  } phase_e;

  typedef enum logic [1:0] {
    REG_IN = 2'd0, REG_OUT = 2'd1, REG_POL = 2'd2, REG_CFG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cx_regs.sv
module i2cx_regs
  import i2cx_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  input  reg_sel_e     rd_sel,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] out_q,
  output logic [W-1:0] cfg_q
);
  logic [W-1:0] pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        REG_OUT: out_q <= wr_data;
        REG_POL: pol_q <= wr_data;
        REG_CFG: cfg_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      REG_IN:  rd_data = pin_in ^ pol_q;
      REG_OUT: rd_data = out_q;
      REG_POL: rd_data = pol_q;
      default: rd_data = cfg_q;
    endcase
  end

  // R10: a write aimed at the input register leaves all storage alone
  a_r10_input_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output reg_sel_e          wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output reg_sel_e          ptr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txsh;
  logic              ack_phase;
  logic              rw;
  logic              mack;

  // commit at the fall that closes the acknowledge clock of a data byte
  assign wr_en   = (phase == PH_WDATA) && ack_phase && scl_fall && !start_det && !stop_det;
  assign wr_sel  = ptr;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ack_phase <= 1'b0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= REG_IN;
    end else if (start_det) begin
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      case (phase)
        PH_ADDR, PH_CMD, PH_WDATA: begin
          if (!ack_phase) begin
            if (scl_rise && bit_cnt < FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (phase == PH_ADDR) begin
                if (shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap}) begin
                  ack_phase <= 1'b1;
                  sda_oe    <= 1'b1;
                  rw        <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end else if (phase == PH_CMD) begin
                if (shreg < BYTE_W'(4)) begin
                  ptr       <= reg_sel_e'(shreg[1:0]);
                  ack_phase <= 1'b1;
                  sda_oe    <= 1'b1;
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                ack_phase <= 1'b1;
                sda_oe    <= 1'b1;
              end
            end
          end else if (scl_fall) begin
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
            if (phase == PH_ADDR) begin
              if (rw) begin
                phase  <= PH_RDATA;
                txsh   <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                phase <= PH_CMD;
              end
            end else if (phase == PH_CMD) begin
              phase <= PH_WDATA;
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == FULL) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              phase   <= PH_RACK;
            end else begin
              txsh   <= txsh << 1;
              sda_oe <= ~txsh[BYTE_W-2];
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              phase  <= PH_RDATA;
              txsh   <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8: an idle target never holds the data line
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
  // R2: the bit counter never runs past one byte
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  // R6: the host owns the line while its acknowledge is sampled
  a_r6_host_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import i2cx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  output logic              scl_low_o,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] pin_in_i,
  output logic [BYTE_W-1:0] pin_out_o,
  output logic [BYTE_W-1:0] pin_drive_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  reg_sel_e          wr_sel, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data, out_q, cfg_q;

  i2cx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cx_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_low_o),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ptr(ptr)
  );

  i2cx_regs #(.W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(ptr), .pin_in(pin_in_i),
    .rd_data(rd_data), .out_q(out_q), .cfg_q(cfg_q)
  );

  assign scl_low_o   = 1'b0;
  assign pin_out_o   = out_q;
  assign pin_drive_o = ~cfg_q;

  // R9: pull-down starts only during SCL low
  a_r9_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_s);
  // R4: port pins move only while SCL is low (after an acknowledge)
  a_r4_pins_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out_o) |-> !scl_s);
endmodule

// File: tb/i2c_port_expander_tb_top.sv
module i2c_port_expander_tb_top;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_low, sda_low;
  logic [1:0] strap = 2'b10;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_drive;
  wire scl_line = scl_m & ~scl_low;
  wire sda_line = sda_m & ~sda_low;

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_out = 8'hFF, exp_pol = 8'h00, exp_cfg = 8'hFF;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  i2c_port_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .scl_low_o(scl_low),
    .sda_i(sda_line), .sda_low_o(sda_low), .strap_i(strap),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_drive_o(pin_drive)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison (R4, R5) and drive-timing monitor (R9, R11)
  always @(posedge clk) begin
    #2;
    check(pin_out === exp_out, "R4 pin_out", pin_out, exp_out);
    check(pin_drive === ~exp_cfg, "R5 pin_drive", pin_drive, ~exp_cfg);
    check(scl_low === 1'b0, "R11 scl_low", {7'd0, scl_low}, 8'h00);
    if (sda_low && !prev_oe) check(scl_m === 1'b0, "R9 drive while SCL high", {7'd0, scl_m}, 8'h00);
    prev_oe = sda_low;
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wait_h(H); scl_m = 1'b1; wait_h(H); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h(H); scl_m = 1'b1; wait_h(H); sda_m = 1'b0; wait_h(H); scl_m = 1'b0; wait_h(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H); scl_m = 1'b1; wait_h(H); sda_m = 1'b1; wait_h(H);
  endtask

  // upd: 0 none, 1 output, 2 polarity, 3 direction (model updated 2 negedges after the closing fall)
  task automatic send_byte(input logic [7:0] b, input int upd, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_h(H); scl_m = 1'b1; wait_h(H/2);
    acked = (sda_line == 1'b0);
    wait_h(H/2); scl_m = 1'b0;
    wait_h(2);
    if (acked) begin
      if (upd == 1) exp_out = b;
      else if (upd == 2) exp_pol = b;
      else if (upd == 3) exp_cfg = b;
    end
    wait_h(H-2);
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_h(H); scl_m = 1'b1; wait_h(H/2);
      b[i] = sda_line; wait_h(H/2); scl_m = 1'b0;
    end
    send_bit(!host_ack);
    sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val, input string tag);
    bit a;
    bus_start();
    send_byte(8'hE4, 0, a); check(a, {tag, " address ack R1"}, {7'd0, a}, 8'h01);
    send_byte(cmd, 0, a);   check(a, {tag, " command ack R2"}, {7'd0, a}, 8'h01);
    send_byte(val, int'(cmd), a); check(a, {tag, " data ack R2"}, {7'd0, a}, 8'h01);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] cmd, input logic [7:0] expv, input string tag);
    bit a; logic [7:0] d;
    bus_start();
    send_byte(8'hE4, 0, a); send_byte(cmd, 0, a);
    bus_start();
    send_byte(8'hE5, 0, a); check(a, {tag, " read address ack R8"}, {7'd0, a}, 8'h01);
    recv_byte(1'b0, d); check(d === expv, {tag, " R6 read"}, d, expv);
    bus_stop();
  endtask

  initial begin
    bit a; logic [7:0] d;
    wait_h(4); rst_n = 1'b1; wait_h(4);
    // R7 reset state
    check(pin_out === 8'hFF, "R7 reset out", pin_out, 8'hFF);
    check(pin_drive === 8'h00, "R7 reset drive", pin_drive, 8'h00);
    check(sda_low === 1'b0, "R7 sda released", {7'd0, sda_low}, 8'h00);

    write_reg(8'h01, 8'hA5, "R4 single");
    check(pin_out === 8'hA5, "R4 output value", pin_out, 8'hA5);
    write_reg(8'h03, 8'h0F, "R5 dir");
    check(pin_drive === 8'hF0, "R5 drive mask", pin_drive, 8'hF0);

    // R4 burst of bytes to one register
    bus_start();
    send_byte(8'hE4, 0, a); send_byte(8'h01, 0, a);
    send_byte(8'h11, 1, a); check(a, "R4 burst ack 1", {7'd0, a}, 8'h01);
    send_byte(8'h22, 1, a); check(a, "R4 burst ack 2", {7'd0, a}, 8'h01);
    send_byte(8'h33, 1, a); check(a, "R4 burst ack 3", {7'd0, a}, 8'h01);
    bus_stop();
    check(pin_out === 8'h33, "R4 burst final", pin_out, 8'h33);

    // R1 wrong strap bits: silent, bytes ignored
    bus_start();
    send_byte(8'hE2, 0, a); check(!a, "R1 mismatch nack", {7'd0, a}, 8'h00);
    send_byte(8'h01, 0, a); check(!a, "R1 ignored cmd", {7'd0, a}, 8'h00);
    send_byte(8'h00, 0, a);
    bus_stop();
    check(pin_out === 8'h33, "R1 pins unchanged", pin_out, 8'h33);

    // R3 unknown command
    bus_start();
    send_byte(8'hE4, 0, a); send_byte(8'h07, 0, a); check(!a, "R3 bad cmd nack", {7'd0, a}, 8'h00);
    send_byte(8'h00, 0, a);
    bus_stop();
    check(pin_out === 8'h33 && pin_drive === 8'hF0, "R3 no change", pin_out, 8'h33);

    // R10 write to input register
    write_reg(8'h00, 8'h5A, "R10");
    check(pin_out === 8'h33, "R10 out untouched", pin_out, 8'h33);

    write_reg(8'h02, 8'hF0, "R6 pol");
    pin_in = 8'h3C;
    // R6 repeated reads of input register with polarity
    bus_start();
    send_byte(8'hE4, 0, a); send_byte(8'h00, 0, a);
    bus_start();
    send_byte(8'hE5, 0, a); check(a, "R8 repeated start ack", {7'd0, a}, 8'h01);
    recv_byte(1'b1, d); check(d === 8'hCC, "R6 input xor 1", d, 8'hCC);
    recv_byte(1'b0, d); check(d === 8'hCC, "R6 input xor 2", d, 8'hCC);
    wait_h(4);
    check(sda_low === 1'b0, "R6 released after nack", {7'd0, sda_low}, 8'h00);
    bus_stop();

    read_reg(8'h01, 8'h33, "out");
    read_reg(8'h03, 8'h0F, "dir");
    read_reg(8'h02, 8'hF0, "pol");
    check(pin_out === 8'h33, "R10 out read back", pin_out, 8'h33);

    // R8 START in the middle of a byte
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hE4, 0, a); check(a, "R8 restart address", {7'd0, a}, 8'h01);
    send_byte(8'h01, 0, a); send_byte(8'h77, 1, a);
    bus_stop();
    check(pin_out === 8'h77, "R8 after restart", pin_out, 8'h77);

    // R6 read without new command keeps the pointer
    bus_start();
    send_byte(8'hE5, 0, a);
    recv_byte(1'b0, d); check(d === 8'h77, "R6 pointer kept", d, 8'h77);
    bus_stop();

    wait_h(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule